// File: doc/BRIEF.md
# Dual-Rail Precharged Split-Carry Lookahead Adder

This block adds two 16-bit operands and a carry-in. Every data signal is carried on two complementary wires, a true rail and a false rail. A phase input sets the mode of operation:

- **Precharge:** every rail inside the block is held at 0.
- **Evaluate:** exactly one rail of each bit rises.

As a result, the number of rail transitions per cycle does not depend on the values being added.

The adder is built from four 4-bit lookahead slices. Each slice reports a group generate and a group propagate. A second-level lookahead unit combines these into the carry-in of each slice.

A mode input selects one of two configurations:

- **Full mode:** one 16-bit sum.
- **Split mode:** the carry path is cut at bit 8, giving two independent byte-wide sums from the same operand pair.

On each clock edge the result, the two lane carry-outs and an illegal-input flag are captured into output registers.

Top module: `dr_split_adder`

## Requirements
- R1: While `rst` is high at a clock edge, every sum and carry-out rail and `err_o` are 0 after that edge.
- R2: A clock edge with `phase` = 1 (precharge) leaves both rails of every sum and carry-out bit at 0, whatever the operand rails.
- R3: After a clock edge with `phase` = 0 (evaluate) and legal, complete inputs, exactly one rail of every sum bit and every carry-out bit is 1.
- R4: With `split` = 0, the registered sum equals (A + B + cin) mod 2^16, and `cout` bit 1 is bit 16 of that total.
- R5: With `split` = 0, `cout` bit 0 is the carry out of bit 7 of the same addition.
- R6: With `split` = 1, sum bits 7:0 equal (A[7:0] + B[7:0] + cin) mod 256, and `cout` bit 0 is the carry out of that byte.
- R7: With `split` = 1, sum bits 15:8 equal (A[15:8] + B[15:8]) mod 256 with a carry-in of 0, whatever the lower byte produces. `cout` bit 1 is the carry out of the upper byte.
- R8: If any operand bit or the carry-in has both rails at 1 during an evaluate edge, `err_o` is 1 after that edge.
- R9: Input pairs with both rails at 1 during a precharge edge have no effect: `err_o` is 0 after that edge.
- R10: A logical 1 is encoded as true rail 1 and false rail 0, and a logical 0 as true rail 0 and false rail 1. This applies to every operand, carry and sum bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; outputs are registered on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| phase | input | 1 | 1 = precharge, 0 = evaluate |
| split | input | 1 | 0 = one 16-bit add, 1 = two independent 8-bit adds |
| a_t | input | 16 | Operand A, true rails |
| a_f | input | 16 | Operand A, false rails |
| b_t | input | 16 | Operand B, true rails |
| b_f | input | 16 | Operand B, false rails |
| cin_t | input | 1 | Carry-in, true rail |
| cin_f | input | 1 | Carry-in, false rail |
| sum_t | output | 16 | Registered sum, true rails |
| sum_f | output | 16 | Registered sum, false rails |
| cout_t | output | 2 | Lane carry-outs, true rails (bit 0 lower lane, bit 1 upper lane) |
| cout_f | output | 2 | Lane carry-outs, false rails |
| err_o | output | 1 | Registered illegal-input flag |

## Verification
The hardest case to reach from the ports is a leak across the split point. A lower byte that produces a carry in split mode must not disturb the upper byte. That leak only becomes visible when the upper byte propagates in every position.

The stimulus therefore pairs lower bytes that overflow (for example 0xFF + 0x01, or a carry-in on 0xFF + 0x00) with upper bytes of 0xFF + 0x00. With those operands, a leaked carry would flip all eight upper sum bits and the upper carry-out. The same operands are also replayed in full mode, where the carry must ripple through.

Precharge cycles are interleaved between evaluations, including precharge cycles that carry garbage both-high rails. This shows that the illegal-input flag and the outputs respond only to the evaluate phase.

// File: rtl/dr_adder_pkg.sv
package dr_adder_pkg;

    // One dual-rail bit: t high means logical 1, f high means logical 0,
    // both low means not yet evaluated (precharged).
    typedef struct packed {
        logic t;
        logic f;
    } dr_t;

    localparam int SLICE_W = 4;

    // Monotone dual-rail gates: each output rail only rises when inputs rise.
    function automatic dr_t dr_and(input dr_t x, input dr_t y);
        dr_t r;
        r.t = x.t & y.t;
        r.f = x.f | y.f;
        return r;
    endfunction

    function automatic dr_t dr_or(input dr_t x, input dr_t y);
        dr_t r;
        r.t = x.t | y.t;
        r.f = x.f & y.f;
        return r;
    endfunction

    function automatic dr_t dr_xor(input dr_t x, input dr_t y);
        dr_t r;
        r.t = (x.t & y.f) | (x.f & y.t);
        r.f = (x.t & y.t) | (x.f & y.f);
        return r;
    endfunction

    // Encoding of a constant during evaluate; all-low during precharge.
    function automatic dr_t dr_const(input logic val, input logic eval);
        dr_t r;
        r.t = val & eval;
        r.f = ~val & eval;
        return r;
    endfunction

endpackage

// File: rtl/dr_cla_slice.sv
module dr_cla_slice
    import dr_adder_pkg::*;
#(
    parameter int WIDTH = SLICE_W
) (
    input  dr_t [WIDTH-1:0] a,
    input  dr_t [WIDTH-1:0] b,
    input  dr_t             cin,
    output dr_t [WIDTH-1:0] s,
    output dr_t             grp_g,
    output dr_t             grp_p
);

    dr_t [WIDTH-1:0] gen;
    dr_t [WIDTH-1:0] prop;
    dr_t [WIDTH-1:0] cy;

    always_comb begin
        for (int i = 0; i < WIDTH; i++) begin
            gen[i]  = dr_and(a[i], b[i]);
            prop[i] = dr_xor(a[i], b[i]);
        end
        // Bit carries expanded from the slice carry-in.
        cy[0] = cin;
        for (int i = 1; i < WIDTH; i++) begin
            cy[i] = dr_or(gen[i-1], dr_and(prop[i-1], cy[i-1]));
        end
        for (int i = 0; i < WIDTH; i++) begin
            s[i] = dr_xor(prop[i], cy[i]);
        end
        // Group terms are independent of the carry-in.
        grp_g = gen[0];
        grp_p = prop[0];
        for (int i = 1; i < WIDTH; i++) begin
            grp_g = dr_or(gen[i], dr_and(prop[i], grp_g));
            grp_p = dr_and(prop[i], grp_p);
        end
    end

endmodule

// File: rtl/dr_lookahead.sv
module dr_lookahead
    import dr_adder_pkg::*;
#(
    parameter int GROUPS = 4
) (
    input  logic              eval,
    input  logic              split,
    input  dr_t [GROUPS-1:0]  gg,
    input  dr_t [GROUPS-1:0]  gp,
    input  dr_t               cin,
    output dr_t [GROUPS-1:0]  slice_cin,
    output dr_t [1:0]         lane_co
);

    localparam int CUT = GROUPS / 2;

    always_comb begin
        dr_t run;
        lane_co = '0;
        run     = cin;
        for (int k = 0; k < GROUPS; k++) begin
            if (k == CUT) begin
                // Carry leaving the lower lane is always reported.
                lane_co[0] = run;
                // Split mode: upper lane starts from a dual-rail zero.
                if (split) run = dr_const(1'b0, eval);
            end
            slice_cin[k] = run;
            run = dr_or(gg[k], dr_and(gp[k], run));
        end
        lane_co[1] = run;
    end

endmodule

// File: rtl/dr_split_adder.sv
module dr_split_adder
    import dr_adder_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         phase,
    input  logic         split,
    input  logic [W-1:0] a_t,
    input  logic [W-1:0] a_f,
    input  logic [W-1:0] b_t,
    input  logic [W-1:0] b_f,
    input  logic         cin_t,
    input  logic         cin_f,
    output logic [W-1:0] sum_t,
    output logic [W-1:0] sum_f,
    output logic [1:0]   cout_t,
    output logic [1:0]   cout_f,
    output logic         err_o
);

    localparam int NSL = W / SLICE_W;

    logic            eval;
    dr_t [W-1:0]     a_dr, b_dr, s_dr;
    dr_t             c_dr;
    dr_t [NSL-1:0]   gg, gp, sl_cin;
    dr_t [1:0]       lane_co;
    logic            illegal;
    logic            in_ok;

    assign eval = ~phase;

    // Input gating: precharge forces every internal rail low.
    always_comb begin
        for (int i = 0; i < W; i++) begin
            a_dr[i].t = a_t[i] & eval;
            a_dr[i].f = a_f[i] & eval;
            b_dr[i].t = b_t[i] & eval;
            b_dr[i].f = b_f[i] & eval;
        end
        c_dr.t = cin_t & eval;
        c_dr.f = cin_f & eval;
    end

    assign illegal = (|(a_t & a_f)) | (|(b_t & b_f)) | (cin_t & cin_f);
    assign in_ok   = (&(a_t ^ a_f)) & (&(b_t ^ b_f)) & (cin_t ^ cin_f);

    for (genvar g = 0; g < NSL; g++) begin : g_slice
        dr_cla_slice #(.WIDTH(SLICE_W)) u_slice (
            .a     (a_dr[g*SLICE_W +: SLICE_W]),
            .b     (b_dr[g*SLICE_W +: SLICE_W]),
            .cin   (sl_cin[g]),
            .s     (s_dr[g*SLICE_W +: SLICE_W]),
            .grp_g (gg[g]),
            .grp_p (gp[g])
        );
    end

    dr_lookahead #(.GROUPS(NSL)) u_la (
        .eval      (eval),
        .split     (split),
        .gg        (gg),
        .gp        (gp),
        .cin       (c_dr),
        .slice_cin (sl_cin),
        .lane_co   (lane_co)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_t  <= '0;
            sum_f  <= '0;
            cout_t <= '0;
            cout_f <= '0;
            err_o  <= 1'b0;
        end else begin
            for (int i = 0; i < W; i++) begin
                sum_t[i] <= s_dr[i].t;
                sum_f[i] <= s_dr[i].f;
            end
            cout_t <= {lane_co[1].t, lane_co[0].t};
            cout_f <= {lane_co[1].f, lane_co[0].f};
            err_o  <= eval & illegal;
        end
    end

    // R1: reset leaves all rails and the flag low
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (sum_t == '0 && sum_f == '0 && cout_t == '0 && cout_f == '0 && !err_o));

    // R2: precharge edge leaves every output rail low
    assert_precharge_low_R2: assert property (@(posedge clk) disable iff (rst)
        phase |=> (sum_t == '0 && sum_f == '0 && cout_t == '0 && cout_f == '0));

    // R3: evaluate with complete legal inputs gives one rail per sum bit
    assert_sum_one_rail_R3: assert property (@(posedge clk) disable iff (rst)
        (!phase && in_ok) |=> ((sum_t ^ sum_f) == '1 && (sum_t & sum_f) == '0));

    // R3: same for the lane carry-outs
    assert_cout_one_rail_R3: assert property (@(posedge clk) disable iff (rst)
        (!phase && in_ok) |=> ((cout_t ^ cout_f) == 2'b11));

    // R9: precharge never raises the flag
    assert_no_err_precharge_R9: assert property (@(posedge clk) disable iff (rst)
        phase |=> !err_o);

endmodule

// File: tb/dr_split_adder_test.sv
module dr_split_adder_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        phase = 1'b1;
    logic        split = 1'b0;
    logic [15:0] a_t = '0, a_f = '0, b_t = '0, b_f = '0;
    logic        cin_t = 1'b0, cin_f = 1'b0;
    logic [15:0] sum_t, sum_f;
    logic [1:0]  cout_t, cout_f;
    logic        err_o;

    int checks = 0;
    int failures = 0;

    typedef struct {
        bit          pre;
        bit          bad;
        bit          md;
        logic [15:0] s;
        logic [1:0]  co;
    } exp_t;
    exp_t q[$];

    always #5 clk = ~clk;

    dr_split_adder uut (
        .clk(clk), .rst(rst), .phase(phase), .split(split),
        .a_t(a_t), .a_f(a_f), .b_t(b_t), .b_f(b_f),
        .cin_t(cin_t), .cin_f(cin_f),
        .sum_t(sum_t), .sum_f(sum_f), .cout_t(cout_t), .cout_f(cout_f),
        .err_o(err_o)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: bad = 0 legal, 1 A bit 5 both-high, 2 carry-in both-high
    task automatic apply(input bit ph, input bit md, input logic [15:0] a,
                         input logic [15:0] b, input bit ci, input int bad);
        exp_t e;
        logic [16:0] full;
        logic [8:0]  lo, hi;
        @(negedge clk);
        phase = ph; split = md;
        a_t = a; a_f = ~a; b_t = b; b_f = ~b; cin_t = ci; cin_f = ~ci;
        if (bad == 1) begin a_t[5] = 1'b1; a_f[5] = 1'b1; end
        if (bad == 2) begin cin_t = 1'b1; cin_f = 1'b1; end
        full = {1'b0, a} + {1'b0, b} + {16'd0, ci};
        lo   = {1'b0, a[7:0]} + {1'b0, b[7:0]} + {8'd0, ci};
        hi   = {1'b0, a[15:8]} + {1'b0, b[15:8]};
        e.pre = ph; e.bad = (bad != 0); e.md = md;
        if (md) begin
            e.s  = {hi[7:0], lo[7:0]};
            e.co = {hi[8], lo[8]};
        end else begin
            e.s  = full[15:0];
            e.co = {full[16], lo[8]};
        end
        q.push_back(e);
    endtask

    // Monitor / scoreboard
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                e = q.pop_front();
                if (e.pre) begin
                    chk(sum_t == 0 && sum_f == 0 && cout_t == 0 && cout_f == 0, "R2 precharge rails",
                        {sum_t, sum_f}, 32'd0);
                    chk(err_o == 1'b0, "R9 precharge flag", {31'd0, err_o}, 32'd0);
                end else if (e.bad) begin
                    chk(err_o == 1'b1, "R8 illegal flag", {31'd0, err_o}, 32'd1);
                end else begin
                    chk((sum_t ^ sum_f) == 16'hffff && (cout_t ^ cout_f) == 2'b11, "R3 one rail",
                        {sum_t, sum_f}, {e.s, ~e.s});
                    chk(sum_f == ~sum_t && cout_f == ~cout_t, "R10 false rail", {sum_f, 14'd0, cout_f},
                        {~sum_t, 14'd0, ~cout_t});
                    chk(err_o == 1'b0, "R8 no flag on legal", {31'd0, err_o}, 32'd0);
                    if (e.md) begin
                        chk(sum_t[7:0] == e.s[7:0] && cout_t[0] == e.co[0], "R6 lower lane",
                            {sum_t[7:0], 7'd0, cout_t[0]}, {e.s[7:0], 7'd0, e.co[0]});
                        chk(sum_t[15:8] == e.s[15:8] && cout_t[1] == e.co[1], "R7 upper lane",
                            {sum_t[15:8], 7'd0, cout_t[1]}, {e.s[15:8], 7'd0, e.co[1]});
                    end else begin
                        chk(sum_t == e.s && cout_t[1] == e.co[1], "R4 full sum",
                            {sum_t, 15'd0, cout_t[1]}, {e.s, 15'd0, e.co[1]});
                        chk(cout_t[0] == e.co[0], "R5 bit7 carry", {31'd0, cout_t[0]}, {31'd0, e.co[0]});
                    end
                end
            end
        end
    end

    initial begin
        #2000000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: reset state, with garbage on the inputs
        @(negedge clk);
        phase = 1'b0; a_t = '1; a_f = '1;
        repeat (3) @(negedge clk);
        chk(sum_t == 0 && sum_f == 0 && cout_t == 0 && cout_f == 0 && !err_o, "R1 reset",
            {sum_t, sum_f}, 32'd0);
        rst = 1'b0; phase = 1'b1; a_t = '0; a_f = '0;
        @(negedge clk);

        // Full mode directed
        apply(0, 0, 16'h0000, 16'h0000, 0, 0); apply(1, 0, 16'h0, 16'h0, 0, 0);
        apply(0, 0, 16'hffff, 16'h0001, 0, 0); apply(1, 0, 16'h0, 16'h0, 0, 0);
        apply(0, 0, 16'h00ff, 16'h0001, 0, 0); apply(1, 0, 16'h0, 16'h0, 0, 0);
        apply(0, 0, 16'hff00, 16'h00ff, 1, 0); apply(1, 0, 16'h0, 16'h0, 0, 0);
        apply(0, 0, 16'hffff, 16'hffff, 1, 0); apply(1, 0, 16'h0, 16'h0, 0, 0);
        // Split mode: lower overflow next to a fully propagating upper byte (R7)
        apply(0, 1, 16'hff00, 16'h00ff, 1, 0); apply(1, 1, 16'h0, 16'h0, 0, 0);
        apply(0, 1, 16'hffff, 16'h0001, 0, 0); apply(1, 1, 16'h0, 16'h0, 0, 0);
        apply(0, 1, 16'hffff, 16'hffff, 1, 0); apply(1, 1, 16'h0, 16'h0, 0, 0);
        apply(0, 1, 16'h8080, 16'h8080, 0, 0); apply(1, 1, 16'h0, 16'h0, 0, 0);
        // R8 illegal inputs during evaluate
        apply(0, 0, 16'h1234, 16'h4321, 0, 1); apply(1, 0, 16'h0, 16'h0, 0, 0);
        apply(0, 1, 16'h1234, 16'h4321, 0, 2); apply(1, 0, 16'h0, 16'h0, 0, 0);
        // R9 illegal inputs during precharge, back to back with a legal evaluate
        apply(1, 0, 16'h5555, 16'haaaa, 1, 1);
        apply(0, 0, 16'h5555, 16'haaaa, 1, 0);
        apply(1, 1, 16'hffff, 16'h0000, 0, 2);
        // Random patterns in both modes
        for (int n = 0; n < 60; n++) begin
            apply(0, n[0], 16'($urandom), 16'($urandom), 1'($urandom), 0);
            apply(1, n[0], 16'($urandom), 16'($urandom), 0, 0);
        end
        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule